// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block is the receive half of an asynchronous serial port. It brings the serial line into the clock domain, then oversamples it at sixteen times the bit rate. It finds a start bit and confirms it at mid-bit. It then takes seven or eight data bits, least significant bit first, an optional parity bit and the first stop bit. Each finished character goes into a single receive buffer register, and a one-cycle completion pulse marks the end of the frame.

Three error conditions are gathered in an 8-bit status byte that software can only read:

- a parity mismatch,
- a stop bit found low,
- a character that arrived while the previous one was still unread.

A bus read strobe for the status byte clears the error flags. A separate read strobe for the buffer marks the held character as consumed. When an overrun occurs, the new character is dropped and the older one is kept.

The bit rate comes from a fixed divisor input, which gives one oversampling tick every `div` clock cycles. Reception runs only when both the power enable and the receive enable are high. When both enables are low, the status byte is cleared.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset, `stat`, `rx_data` and `rx_done` are all zero.
- R2: With parity mode 00 and `len8`=1, a frame made of a low start bit, 8 data bits (LSB first) and a high stop bit loads the data into `rx_data`. `rx_done` is high for exactly one cycle, and that is the same cycle in which `rx_data` first shows the new character.
- R3: With `len8`=0, 7 data bits are received and bit 7 of `rx_data` reads 0.
- R4: The parity mode is coded as follows: 00 = no parity bit, 01 = a parity bit is present but never checked, 10 = odd, 11 = even. In modes 10 and 11, a parity bit that breaks the chosen parity sets `stat[2]`. In modes 00 and 01 `stat[2]` is never set.
- R5: A low first stop bit sets `stat[1]`.
- R6: Only the first stop bit is sampled. A new start bit that follows one stop bit directly is received as the next character.
- R7: If a character completes while the buffer holds a character not yet taken by `rd_buf`, then `stat[0]` is set, the new character is discarded and `rx_data` keeps the old one. A `rd_buf` in the completion cycle counts as taking the old character, so the new one is stored.
- R8: A cycle with `rd_stat` high clears the flags that were held before it. Flags raised by a frame completing in that same cycle survive, and are cleared by the following read.
- R9: While `pwr_en` and `rx_en` are both 0, `stat` is held at zero. Unless both enables are 1, line activity produces no `rx_done` and leaves `rx_data` unchanged.
- R10: `stat[7:3]` always reads 0.
- R11: A low pulse on the line that ends before mid-bit is rejected as a false start and produces no character.
- R12: The oversampling tick period equals `div` clock cycles. A bit period of 16·`div` cycles is received correctly for `div` > 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line, idles high |
| pwr_en | input | 1 | Power enable |
| rx_en | input | 1 | Receive enable |
| par_mode | input | 2 | Parity mode: 00 none, 01 unchecked, 10 odd, 11 even |
| len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| div | input | DIV_W | Clock cycles per oversampling tick |
| rd_buf | input | 1 | Bus read strobe for the receive buffer |
| rd_stat | input | 1 | Bus read strobe for the status byte |
| rx_data | output | 8 | Receive buffer contents |
| stat | output | 8 | Status byte: bit 2 parity, bit 1 framing, bit 0 overrun |
| rx_done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The assertions check, on every cycle, these properties:

- the upper status bits stay zero;
- the completion pulse lasts a single cycle;
- error flags rise only together with that pulse;
- a status read leaves only freshly raised flags;
- the disable clear takes effect;
- no completion appears while the receiver is disabled;
- the buffer holds still when an overrun is flagged.

Other behaviour can only be shown by the bench's scenarios, because it depends on what the bench drove onto the line. This covers:

- whether the assembled character and its parity verdict are right;
- whether the data bits are taken in LSB-first order;
- the seven-bit length;
- rejection of a false start;
- a back-to-back frame;
- timing that scales with the divisor.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OSR    = 16;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(OSR);
    localparam int BIT_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    localparam logic [1:0] PM_NONE = 2'b00;
    localparam logic [1:0] PM_ZERO = 2'b01;
    localparam logic [1:0] PM_ODD  = 2'b10;
    localparam logic [1:0] PM_EVEN = 2'b11;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rx_frame_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (div == '0) ? '0 : div - 1'b1;
        tick  = run && (cnt_q >= limit);
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic       rx,
    input  logic       len8,
    input  logic [1:0] par_mode,
    output logic       frame_end,
    output rx_frame_t  frame
);
    localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] sh;
        logic              par;
    } fsm_t;

    fsm_t s_d, s_q;
    logic [BIT_W-1:0]  last_bit;
    logic [DATA_W-1:0] dat;
    logic              ones;

    always_comb begin
        last_bit = len8 ? BIT_W'(DATA_W - 1) : BIT_W'(DATA_W - 2);
        dat      = len8 ? s_q.sh : {1'b0, s_q.sh[DATA_W-1:1]};
        ones     = ^dat;

        frame.data = dat;
        frame.ferr = ~rx;
        case (par_mode)
            PM_ODD:  frame.perr = ~(ones ^ s_q.par);
            PM_EVEN: frame.perr = ones ^ s_q.par;
            default: frame.perr = 1'b0;
        endcase

        s_d       = s_q;
        frame_end = 1'b0;
        if (!run) begin
            s_d.st   = RX_IDLE;
            s_d.cnt  = '0;
            s_d.bitn = '0;
        end else if (tick) begin
            case (s_q.st)
                RX_IDLE: begin
                    if (!rx) begin
                        s_d.st  = RX_START;
                        s_d.cnt = '0;
                        s_d.sh  = '0;
                    end
                end
                RX_START: begin
                    if (s_q.cnt == MID_C) begin
                        s_d.cnt  = '0;
                        s_d.bitn = '0;
                        s_d.st   = rx ? RX_IDLE : RX_DATA;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (s_q.cnt == FULL_C) begin
                        s_d.cnt = '0;
                        s_d.sh  = {rx, s_q.sh[DATA_W-1:1]};
                        if (s_q.bitn == last_bit)
                            s_d.st = (par_mode == PM_NONE) ? RX_STOP : RX_PAR;
                        else
                            s_d.bitn = s_q.bitn + 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (s_q.cnt == FULL_C) begin
                        s_d.cnt = '0;
                        s_d.par = rx;
                        s_d.st  = RX_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (s_q.cnt == FULL_C) begin
                        s_d.cnt   = '0;
                        s_d.st    = RX_IDLE;
                        frame_end = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= RX_IDLE;
            s_q.cnt  <= '0;
            s_q.bitn <= '0;
            s_q.sh   <= '0;
            s_q.par  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              frame_end,
    input  rx_frame_t         frame,
    input  logic              rd_buf,
    input  logic              rd_stat,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        stat,
    output logic              rx_done
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              full;
        logic              pe;
        logic              fe;
        logic              ove;
        logic              done;
    } st_t;

    st_t r_d, r_q;
    logic lost;

    always_comb begin
        r_d      = r_q;
        r_d.done = frame_end;
        lost     = r_q.full && !rd_buf;

        if (clr || rd_stat) begin
            r_d.pe  = 1'b0;
            r_d.fe  = 1'b0;
            r_d.ove = 1'b0;
        end

        if (frame_end) begin
            r_d.pe  = r_d.pe | frame.perr;
            r_d.fe  = r_d.fe | frame.ferr;
            r_d.ove = r_d.ove | lost;
            if (!lost) begin
                r_d.hold = frame.data;
                r_d.full = 1'b1;
            end
        end else if (rd_buf) begin
            r_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_data = r_q.hold;
    assign stat    = {5'b0, r_q.pe, r_q.fe, r_q.ove};
    assign rx_done = r_q.done;
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
    import uart_rx_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             pwr_en,
    input  logic             rx_en,
    input  logic [1:0]       par_mode,
    input  logic             len8,
    input  logic [DIV_W-1:0] div,
    input  logic             rd_buf,
    input  logic             rd_stat,
    output logic [7:0]       rx_data,
    output logic [7:0]       stat,
    output logic             rx_done
);
    logic      rx_s;
    logic      run;
    logic      clr;
    logic      tick;
    logic      frame_end;
    rx_frame_t frame;

    assign run = pwr_en && rx_en;
    assign clr = !pwr_en && !rx_en;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
    );

    uart_rx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .rx(rx_s),
        .len8(len8), .par_mode(par_mode),
        .frame_end(frame_end), .frame(frame)
    );

    uart_rx_status u_status (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .frame_end(frame_end), .frame(frame),
        .rd_buf(rd_buf), .rd_stat(rd_stat),
        .rx_data(rx_data), .stat(stat), .rx_done(rx_done)
    );
endmodule

// File: rtl/uart_rx_stat_chk.sv
module uart_rx_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_en,
    input logic       rx_en,
    input logic [1:0] par_mode,
    input logic       rd_buf,
    input logic       rd_stat,
    input logic [7:0] rx_data,
    input logic [7:0] stat,
    input logic       rx_done
);
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat[7:3] == 5'b0);

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    p_pe_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[2]) |-> rx_done);

    p_pe_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !par_mode[1]) |-> !$rose(stat[2]));

    p_fe_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> rx_done);

    p_ovr_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> (rx_done && $stable(rx_data)));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (rx_done || stat[2:0] == 3'b0));

    p_off_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && !rx_en) |=> stat == 8'h00);

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_en && rx_en) |=> !rx_done);
endmodule

bind uart_rx_stat uart_rx_stat_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en),
    .par_mode(par_mode), .rd_buf(rd_buf), .rd_stat(rd_stat),
    .rx_data(rx_data), .stat(stat), .rx_done(rx_done)
);

// File: tb/sim_uart_rx_stat.sv
`timescale 1ns/1ps
module sim_uart_rx_stat;
    localparam int SYNC = 2;
    localparam int DW   = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic          pwr_en = 1'b1;
    logic          rx_en = 1'b1;
    logic [1:0]    par_mode = 2'b00;
    logic          len8 = 1'b1;
    logic [DW-1:0] div = 12'd1;
    logic          rd_buf = 1'b0;
    logic          rd_stat = 1'b0;
    logic [7:0]    rx_data;
    logic [7:0]    stat;
    logic          rx_done;

    uart_rx_stat #(.DIV_W(DW), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .pwr_en(pwr_en), .rx_en(rx_en),
        .par_mode(par_mode), .len8(len8), .div(div), .rd_buf(rd_buf),
        .rd_stat(rd_stat), .rx_data(rx_data), .stat(stat), .rx_done(rx_done)
    );

    always #4 clk = ~clk;

    typedef struct {
        int       due;
        bit [7:0] data;
        bit       pe;
        bit       fe;
    } ev_t;

    ev_t   pend[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    last_due = 0;
    bit    model_on = 1'b1;
    string cur_req = "R1";

    bit [7:0] m_buf;
    bit       m_full, m_pe, m_fe, m_ove, m_done;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // reference model, evaluated once per clock on the falling edge
    always @(negedge clk) begin
        ev_t e;
        bit  ev, lost;
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (!rst_n) begin
            m_buf = 0; m_full = 0; m_pe = 0; m_fe = 0; m_ove = 0; m_done = 0;
        end else begin
            ev = 0;
            if (pend.size() > 0 && pend[0].due < cyc) begin
                e = pend.pop_front();
                chk(cur_req, 32'(cyc), 32'(e.due));
            end
            if (pend.size() > 0 && pend[0].due == cyc) begin
                ev = 1;
                e = pend.pop_front();
            end
            m_done = ev;
            if ((!pwr_en && !rx_en) || rd_stat) begin
                m_pe = 0; m_fe = 0; m_ove = 0;
            end
            if (ev) begin
                lost = m_full && !rd_buf;
                m_pe |= e.pe;
                m_fe |= e.fe;
                m_ove |= lost;
                if (!lost) begin
                    m_buf = e.data;
                    m_full = 1;
                end
            end else if (rd_buf) begin
                m_full = 0;
            end
            chk("R10", 32'(stat[7:3]), 0);
            if (model_on) begin
                chk(cur_req, 32'(rx_done), 32'(m_done));
                chk(cur_req, 32'(rx_data), 32'(m_buf));
                chk(cur_req, 32'(stat), 32'({m_pe, m_fe, m_ove}));
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_stat();
        @(negedge clk); #1 rd_stat = 1'b1;
        @(negedge clk); #1 rd_stat = 1'b0;
    endtask

    task automatic read_buf();
        @(negedge clk); #1 rd_buf = 1'b1;
        @(negedge clk); #1 rd_buf = 1'b0;
    endtask

    task automatic send_frame(input bit [7:0] d, input bit l8, input bit [1:0] pm,
                              input bit badp, input bit stopv, input int bitc,
                              input bit expect_rx);
        int       nb;
        bit [7:0] dv;
        bit       pbit;
        ev_t      e;
        nb = l8 ? 8 : 7;
        dv = l8 ? d : {1'b0, d[6:0]};
        case (pm)
            2'b10:   pbit = ~(^dv);
            2'b11:   pbit = ^dv;
            default: pbit = 1'b0;
        endcase
        if (badp) pbit = ~pbit;
        @(negedge clk); #1 rxd = 1'b0;
        last_due = cyc + 9 + SYNC + 16 * (nb + ((pm != 2'b00) ? 1 : 0) + 1);
        if (expect_rx && model_on) begin
            e.due = last_due; e.data = dv;
            e.pe = badp && pm[1]; e.fe = !stopv;
            pend.push_back(e);
        end
        repeat (bitc) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            #1 rxd = dv[i];
            repeat (bitc) @(negedge clk);
        end
        if (pm != 2'b00) begin
            #1 rxd = pbit;
            repeat (bitc) @(negedge clk);
        end
        #1 rxd = stopv;
        repeat (bitc) @(negedge clk);
        #1 rxd = 1'b1;
    endtask

    initial begin
        idle(4);
        #1 rst_n = 1'b1;
        idle(1);
        chk("R1", 32'(stat), 0);
        chk("R1", 32'(rx_data), 0);
        chk("R1", 32'(rx_done), 0);

        // R2: 8-bit frames, no parity, LSB first
        cur_req = "R2";
        send_frame(8'hA5, 1, 2'b00, 0, 1, 16, 1); idle(4); read_buf();
        send_frame(8'h3C, 1, 2'b00, 0, 1, 16, 1); idle(4);
        chk("R2", 32'(rx_data), 32'h3C);
        read_buf();

        // R3: 7-bit length
        cur_req = "R3";
        len8 = 1'b0;
        send_frame(8'hFF, 0, 2'b00, 0, 1, 16, 1); idle(4);
        chk("R3", 32'(rx_data), 32'h7F);
        read_buf();
        len8 = 1'b1;

        // R4: parity modes
        cur_req = "R4";
        par_mode = 2'b10;
        send_frame(8'h13, 1, 2'b10, 0, 1, 16, 1); idle(4); read_buf();
        send_frame(8'h13, 1, 2'b10, 1, 1, 16, 1); idle(4);
        chk("R4", 32'(stat), 32'h04);
        read_buf(); read_stat();
        par_mode = 2'b11;
        send_frame(8'h81, 1, 2'b11, 1, 1, 16, 1); idle(4);
        chk("R4", 32'(stat), 32'h04);
        read_buf(); read_stat();
        send_frame(8'h81, 1, 2'b11, 0, 1, 16, 1); idle(4); read_buf();
        par_mode = 2'b01;
        send_frame(8'h5A, 1, 2'b01, 1, 1, 16, 1); idle(4);
        chk("R4", 32'(stat), 32'h00);
        read_buf();
        par_mode = 2'b00;

        // R5: low stop bit
        cur_req = "R5";
        send_frame(8'h77, 1, 2'b00, 0, 0, 16, 1); idle(30);
        chk("R5", 32'(stat), 32'h02);
        read_buf(); read_stat();

        // R6: back-to-back frames after one stop bit
        cur_req = "R6";
        send_frame(8'h11, 1, 2'b00, 0, 1, 16, 1);
        fork
            send_frame(8'h22, 1, 2'b00, 0, 1, 16, 1);
            begin idle(60); read_buf(); end
        join
        idle(4);
        chk("R6", 32'(rx_data), 32'h22);
        read_buf();

        // R7: overrun keeps the old character
        cur_req = "R7";
        send_frame(8'hC3, 1, 2'b00, 0, 1, 16, 1); idle(4);
        send_frame(8'h3D, 1, 2'b00, 0, 1, 16, 1); idle(4);
        chk("R7", 32'(rx_data), 32'hC3);
        chk("R7", 32'(stat), 32'h01);
        read_stat(); read_buf();
        send_frame(8'h6E, 1, 2'b00, 0, 1, 16, 1); idle(4);
        chk("R7", 32'(rx_data), 32'h6E);
        read_buf();

        // R8: status read in the completion cycle
        cur_req = "R8";
        par_mode = 2'b10;
        fork
            send_frame(8'h0F, 1, 2'b10, 1, 1, 16, 1);
            begin
                @(negedge clk); #2;
                while (cyc != last_due - 1) begin @(negedge clk); #1; end
                rd_stat = 1'b1;
                @(negedge clk); #1 rd_stat = 1'b0;
            end
        join
        idle(4);
        chk("R8", 32'(stat), 32'h04);
        read_stat(); idle(1);
        chk("R8", 32'(stat), 32'h00);
        read_buf();
        par_mode = 2'b00;

        // R9: enables
        cur_req = "R9";
        rx_en = 1'b0;
        send_frame(8'h99, 1, 2'b00, 0, 1, 16, 0); idle(4);
        chk("R9", 32'(rx_data), 32'h0F);
        rx_en = 1'b1;
        send_frame(8'h44, 1, 2'b00, 0, 0, 16, 1); idle(30);
        chk("R9", 32'(stat), 32'h02);
        @(negedge clk); #1 begin pwr_en = 1'b0; rx_en = 1'b0; end
        idle(2);
        chk("R9", 32'(stat), 32'h00);
        #1 begin pwr_en = 1'b1; rx_en = 1'b1; end
        read_buf();

        // R11: short low pulse
        cur_req = "R11";
        @(negedge clk); #1 rxd = 1'b0;
        idle(4); #1 rxd = 1'b1;
        idle(40);
        chk("R11", 32'(rx_data), 32'h44);
        chk("R11", 32'(rx_done), 0);

        // R12: divisor 3, bit period 48 cycles
        cur_req = "R12";
        model_on = 1'b0;
        div = 12'd3;
        send_frame(8'hB6, 1, 2'b00, 0, 1, 48, 0); idle(10);
        chk("R12", 32'(rx_data), 32'hB6);
        chk("R12", 32'(stat), 32'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule